// File: doc/BRIEF.md
# Periodic Conversion Trigger Sequencer

This block sits in front of the sample FIFO of a converter and decides when the FIFO read logic gets a trigger. In plain mode (sequencing disabled), each user trigger is passed on as one strobe. When sequencing is enabled, one user trigger starts a burst. The user trigger itself produces the first strobe. After that, the block issues its own strobes, one every `periodCfg + 1` clock cycles.

A non-zero `countCfg` limits the burst to that many internal strobes. A zero count lets the burst run until the enable bit is cleared. Either way the sequence ends gracefully. The block stops issuing strobes, waits until the converter reports it is no longer busy, and then raises a sticky completion flag. The flag is cleared by writing a one, and it drives an interrupt through its own enable. Two synchronous resets cut a sequence short at any time. The FIFO-pointer reset only terminates. The full logic reset also clears the flag.

The trigger source is either a hardware or a software strobe, chosen by a select input. In swing mode the FIFO only needs the strobes forwarded, so the same block serves that mode unchanged.

Top module: `periodic_trig_seq`

## Requirements
- R1: With `seqEn` low and the block idle, each selected user trigger pulse gives exactly one `trigOut` pulse in the following cycle, and no sequence starts.
- R2: `trigSrcSw` = 1 selects `swTrig` as the user trigger and `trigSrcSw` = 0 selects `hwTrig`; pulses on the unselected input have no effect on `trigOut`.
- R3: With `seqEn` high and the block idle, a user trigger gives a `trigOut` pulse in the next cycle. Internal pulses then follow, spaced exactly `periodCfg` + 1 cycles apart, using the period captured at the start.
- R4: A start with `countCfg` = N > 0 yields exactly N internal pulses, so N + 1 `trigOut` pulses in total.
- R5: A start with `countCfg` = 0 yields internal pulses without limit while `seqEn` stays high. Once `seqEn` is low, no further pulse is issued.
- R6: When a sequence ends by count or by disable, `doneFlag` rises in the cycle after the first clock edge at which `convBusy` is low and `trigOut` is low. It never rises while the converter is busy.
- R7: User triggers that arrive while a sequence is running or draining are ignored; they add no pulse.
- R8: `fifoRst` or `logicRst` ends any sequence at once: `trigOut` is low from the next cycle, and the terminated sequence does not set `doneFlag`. `logicRst` also clears `doneFlag`, while `fifoRst` leaves it unchanged.
- R9: `doneFlag` stays set until `flagClr` is pulsed high (write-one-to-clear). A set in the same cycle wins over a clear.
- R10: `irqOut` is high exactly when `doneFlag` and `irqEn` are both high.
- R11: After `rstN` reset, `trigOut`, `doneFlag` and `irqOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwTrig | input | 1 | Hardware trigger strobe |
| swTrig | input | 1 | Software trigger strobe |
| trigSrcSw | input | 1 | 1 selects swTrig, 0 selects hwTrig |
| seqEn | input | 1 | Periodic sequencing enable |
| periodCfg | input | PERIOD_W | Interval minus one, in clock cycles |
| countCfg | input | COUNT_W | Internal pulses per burst, 0 = endless |
| convBusy | input | 1 | Converter is processing a sample |
| fifoRst | input | 1 | FIFO pointer reset, terminates a sequence |
| logicRst | input | 1 | Full logic reset, terminates and clears flag |
| flagClr | input | 1 | Write-one-to-clear for doneFlag |
| irqEn | input | 1 | Interrupt enable for doneFlag |
| trigOut | output | 1 | Trigger strobe to the FIFO read logic |
| doneFlag | output | 1 | Sticky sequence-complete flag |
| irqOut | output | 1 | Completion interrupt |

## Verification
The bench goes after four corner cases, each of which a faulty design would get wrong in a visible way:
- A period of zero must give back-to-back pulses. A design that lost the reload would get the spacing wrong.
- A count of one must end after a single internal pulse. An off-by-one in the remaining counter would add or drop a pulse.
- The completion flag must wait one cycle past the converter's busy window. A design that ignored the in-flight conversion would raise it early.
- A trigger arriving during a burst must not restart the burst. A design that restarted on it would add pulses.

The bench also checks that a FIFO-pointer reset in the middle of an endless burst stops the pulses without marking completion. It checks that clearing the enable stops an endless burst for good.

// File: rtl/trigseq_pkg.sv
package trigseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seqState_e;

  // Strobes from control to the counters
  typedef struct packed {
    logic clear;  // drop all counter state
    logic load;   // capture settings at sequence start
    logic step;   // advance the interval counter by one cycle
  } seqCtl_t;
endpackage

// File: rtl/trigseq_datapath.sv
module trigseq_datapath
  import trigseq_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int COUNT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [COUNT_W-1:0]  countCfg,
  output logic                tickDue,
  output logic                lastShot
);
  localparam logic [PERIOD_W-1:0] PER_ZERO = '0;
  localparam logic [COUNT_W-1:0]  CNT_ZERO = '0;
  localparam logic [COUNT_W-1:0]  CNT_ONE  = COUNT_W'(1);

  logic [PERIOD_W-1:0] periodQ;
  logic [PERIOD_W-1:0] intCnt;
  logic [COUNT_W-1:0]  remCnt;
  logic                endless;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= PER_ZERO;
      intCnt  <= PER_ZERO;
      remCnt  <= CNT_ZERO;
      endless <= 1'b0;
    end else if (ctl.clear) begin
      periodQ <= PER_ZERO;
      intCnt  <= PER_ZERO;
      remCnt  <= CNT_ZERO;
      endless <= 1'b0;
    end else if (ctl.load) begin
      periodQ <= periodCfg;
      intCnt  <= periodCfg;
      remCnt  <= countCfg;
      endless <= (countCfg == CNT_ZERO);
    end else if (ctl.step) begin
      if (intCnt == PER_ZERO) begin
        intCnt <= periodQ;
        if (!endless) remCnt <= remCnt - CNT_ONE;
      end else begin
        intCnt <= intCnt - PERIOD_W'(1);
      end
    end
  end

  assign tickDue  = (intCnt == PER_ZERO);
  assign lastShot = !endless && (remCnt == CNT_ONE);
endmodule

// File: rtl/trigseq_ctrl.sv
module trigseq_ctrl
  import trigseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      userTrig,
  input  logic      seqEn,
  input  logic      convBusy,
  input  logic      fifoRst,
  input  logic      logicRst,
  input  logic      flagClr,
  input  logic      tickDue,
  input  logic      lastShot,
  output seqCtl_t   ctl,
  output logic      trigQ,
  output logic      doneQ,
  output seqState_e stateQ
);
  seqState_e stateD;
  logic abort, start, pass, fire, drainDone, trigD;

  always_comb begin
    abort     = fifoRst || logicRst;
    start     = (stateQ == SEQ_IDLE) && seqEn && userTrig;
    pass      = (stateQ == SEQ_IDLE) && !seqEn && userTrig;
    fire      = (stateQ == SEQ_RUN) && seqEn && tickDue;
    drainDone = (stateQ == SEQ_DRAIN) && !convBusy && !trigQ;

    stateD = stateQ;
    if (abort) begin
      stateD = SEQ_IDLE;
    end else begin
      case (stateQ)
        SEQ_IDLE:  if (start) stateD = SEQ_RUN;
        SEQ_RUN: begin
          if (!seqEn)                stateD = SEQ_DRAIN;
          else if (fire && lastShot) stateD = SEQ_DRAIN;
        end
        SEQ_DRAIN: if (drainDone) stateD = SEQ_IDLE;
        default:   stateD = SEQ_IDLE;
      endcase
    end

    ctl.clear = abort;
    ctl.load  = start && !abort;
    ctl.step  = (stateQ == SEQ_RUN) && seqEn && !abort;
    trigD     = !abort && (start || pass || fire);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      trigQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      trigQ  <= trigD;
      if (logicRst)                 doneQ <= 1'b0;
      else if (drainDone && !abort) doneQ <= 1'b1;
      else if (flagClr)             doneQ <= 1'b0;
    end
  end
endmodule

// File: rtl/periodic_trig_seq.sv
module periodic_trig_seq
  import trigseq_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int COUNT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hwTrig,
  input  logic                swTrig,
  input  logic                trigSrcSw,
  input  logic                seqEn,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [COUNT_W-1:0]  countCfg,
  input  logic                convBusy,
  input  logic                fifoRst,
  input  logic                logicRst,
  input  logic                flagClr,
  input  logic                irqEn,
  output logic                trigOut,
  output logic                doneFlag,
  output logic                irqOut
);
  seqCtl_t   ctl;
  seqState_e stateQ;
  logic      userTrig, tickDue, lastShot;

  assign userTrig = trigSrcSw ? swTrig : hwTrig;

  trigseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .userTrig (userTrig),
    .seqEn    (seqEn),
    .convBusy (convBusy),
    .fifoRst  (fifoRst),
    .logicRst (logicRst),
    .flagClr  (flagClr),
    .tickDue  (tickDue),
    .lastShot (lastShot),
    .ctl      (ctl),
    .trigQ    (trigOut),
    .doneQ    (doneFlag),
    .stateQ   (stateQ)
  );

  trigseq_datapath #(
    .PERIOD_W (PERIOD_W),
    .COUNT_W  (COUNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .periodCfg (periodCfg),
    .countCfg  (countCfg),
    .tickDue   (tickDue),
    .lastShot  (lastShot)
  );

  assign irqOut = doneFlag && irqEn;
endmodule

// File: rtl/periodic_trig_seq_chk.sv
module periodic_trig_seq_chk
  import trigseq_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      seqEn,
  input logic      convBusy,
  input logic      fifoRst,
  input logic      logicRst,
  input logic      flagClr,
  input logic      trigOut,
  input logic      doneFlag,
  input seqState_e stateQ
);
  AST_ABORT_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRst || logicRst) |=> !trigOut); // R8

  AST_LOGIC_RST_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    logicRst |=> !doneFlag); // R8

  AST_DONE_AFTER_IDLE_CONV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (!$past(convBusy) && !$past(trigOut))); // R6

  AST_NO_TRIG_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!seqEn && stateQ != SEQ_IDLE) |=> !trigOut); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !flagClr && !logicRst) |=> doneFlag); // R9
endmodule

bind periodic_trig_seq periodic_trig_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .seqEn    (seqEn),
  .convBusy (convBusy),
  .fifoRst  (fifoRst),
  .logicRst (logicRst),
  .flagClr  (flagClr),
  .trigOut  (trigOut),
  .doneFlag (doneFlag),
  .stateQ   (stateQ)
);

// File: tb/sim_periodic_trig_seq.sv
`timescale 1ns/1ps
module sim_periodic_trig_seq;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam int NV = 4;
  localparam logic [7:0] VEC_PER [NV] = '{8'd0, 8'd1, 8'd3, 8'd6};
  localparam logic [7:0] VEC_CNT [NV] = '{8'd1, 8'd2, 8'd4, 8'd3};

  logic clk = 1'b0, rstN = 1'b0;
  logic hwTrig = 0, swTrig = 0, trigSrcSw = 0, seqEn = 0;
  logic [PW-1:0] periodCfg = '0;
  logic [CW-1:0] countCfg = '0;
  logic convBusy = 0, fifoRst = 0, logicRst = 0, flagClr = 0, irqEn = 0;
  logic trigOut, doneFlag, irqOut;

  int checks = 0, errors = 0;
  int cyc = 0, pulseCyc = 0;
  int trigCnt = 0, gapErr = 0, expGap = 1, firstTrigCyc = 0, lastTrigCyc = 0;
  int doneRiseCyc = 0, busyFallCyc = 0, busyCnt = 0, busyLen = 2;
  logic doneSeen = 0;
  int snap;

  always #4 clk = ~clk;

  periodic_trig_seq #(.PERIOD_W(PW), .COUNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .hwTrig(hwTrig), .swTrig(swTrig), .trigSrcSw(trigSrcSw),
    .seqEn(seqEn), .periodCfg(periodCfg), .countCfg(countCfg), .convBusy(convBusy),
    .fifoRst(fifoRst), .logicRst(logicRst), .flagClr(flagClr), .irqEn(irqEn),
    .trigOut(trigOut), .doneFlag(doneFlag), .irqOut(irqOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor and converter model (busy for busyLen cycles per strobe)
  always @(negedge clk) begin
    if (trigOut) begin
      if (trigCnt > 0 && (cyc - lastTrigCyc) != expGap) gapErr++;
      if (trigCnt == 0) firstTrigCyc = cyc;
      lastTrigCyc = cyc;
      trigCnt++;
    end
    if (doneFlag && !doneSeen) doneRiseCyc = cyc;
    doneSeen = doneFlag;
    if (trigOut) busyCnt = busyLen;
    else if (busyCnt > 0) begin
      busyCnt--;
      if (busyCnt == 0) busyFallCyc = cyc;
    end
    convBusy = (busyCnt != 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    trigCnt = 0; gapErr = 0; firstTrigCyc = 0; doneRiseCyc = 0; busyFallCyc = 0;
  endtask

  task automatic pulseTrig(input bit useSw);
    @(negedge clk);
    if (useSw) swTrig = 1; else hwTrig = 1;
    pulseCyc = cyc;
    @(negedge clk);
    hwTrig = 0; swTrig = 0;
  endtask

  task automatic pulseClr();
    @(negedge clk); flagClr = 1;
    @(negedge clk); flagClr = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (doneFlag) break;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 trigOut", int'(trigOut), 0);
    chk("R11 doneFlag", int'(doneFlag), 0);
    chk("R11 irqOut", int'(irqOut), 0);

    // Table walk: R3 spacing, R4 count, R6 completion timing
    seqEn = 1;
    for (int v = 0; v < NV; v++) begin
      periodCfg = VEC_PER[v];
      countCfg  = VEC_CNT[v];
      expGap    = int'(VEC_PER[v]) + 1;
      pulseClr();
      clearStats();
      pulseTrig(0);
      waitDone();
      chk("R3 first strobe delay", firstTrigCyc - pulseCyc, 1);
      chk("R3 interval errors", gapErr, 0);
      chk("R4 total strobes", trigCnt, int'(VEC_CNT[v]) + 1);
      chk("R6 flag set", int'(doneFlag), 1);
      chk("R6 flag one cycle after busy low", doneRiseCyc - busyFallCyc, 1);
    end

    // R6 with a long conversion
    busyLen = 9; periodCfg = 8'd1; countCfg = 8'd1; expGap = 2;
    pulseClr(); clearStats();
    pulseTrig(0);
    waitDone();
    chk("R6 long busy wait", doneRiseCyc - busyFallCyc, 1);
    busyLen = 2;

    // R9 sticky then cleared
    repeat (10) @(negedge clk);
    chk("R9 flag sticky", int'(doneFlag), 1);
    // R10 interrupt gating
    irqEn = 1; @(negedge clk);
    chk("R10 irq with enable", int'(irqOut), 1);
    irqEn = 0; @(negedge clk);
    chk("R10 irq masked", int'(irqOut), 0);
    pulseClr(); @(negedge clk);
    chk("R9 flag cleared", int'(doneFlag), 0);
    irqEn = 1; @(negedge clk);
    chk("R10 irq no flag", int'(irqOut), 0);
    irqEn = 0;

    // R7 retrigger during a burst
    periodCfg = 8'd3; countCfg = 8'd5; expGap = 4;
    clearStats();
    pulseTrig(0);
    repeat (6) @(negedge clk);
    pulseTrig(0);
    waitDone();
    chk("R7 retrigger ignored", trigCnt, 6);
    chk("R7 interval kept", gapErr, 0);
    pulseClr();

    // R5 endless until disabled
    periodCfg = 8'd2; countCfg = 8'd0; expGap = 3;
    clearStats();
    pulseTrig(0);
    repeat (30) @(negedge clk);
    chk("R5 endless keeps going", int'(trigCnt >= 10), 1);
    seqEn = 0;
    waitDone();
    snap = trigCnt;
    repeat (20) @(negedge clk);
    chk("R5 no strobe after disable", trigCnt, snap);
    chk("R5 interval", gapErr, 0);
    chk("R5 flag after disable", int'(doneFlag), 1);

    // R8 fifoRst keeps an existing flag
    @(negedge clk); fifoRst = 1; @(negedge clk); fifoRst = 0;
    chk("R8 fifoRst keeps flag", int'(doneFlag), 1);
    pulseClr();

    // R8 fifoRst aborts an endless burst without completion
    seqEn = 1; periodCfg = 8'd1; countCfg = 8'd0; expGap = 2;
    clearStats();
    pulseTrig(0);
    repeat (8) @(negedge clk);
    fifoRst = 1; @(negedge clk); fifoRst = 0;
    clearStats();
    repeat (20) @(negedge clk);
    chk("R8 no strobe after fifoRst", trigCnt, 0);
    chk("R8 no flag after abort", int'(doneFlag), 0);

    // R8 logicRst clears flag
    countCfg = 8'd1;
    pulseTrig(0);
    waitDone();
    chk("R8 flag before logicRst", int'(doneFlag), 1);
    @(negedge clk); logicRst = 1; @(negedge clk); logicRst = 0;
    chk("R8 logicRst clears flag", int'(doneFlag), 0);

    // R1 plain pass-through
    seqEn = 0; periodCfg = 8'd0; countCfg = 8'd3;
    clearStats();
    pulseTrig(0);
    repeat (10) @(negedge clk);
    chk("R1 single strobe", trigCnt, 1);
    chk("R1 strobe delay", firstTrigCyc - pulseCyc, 1);
    chk("R1 no completion", int'(doneFlag), 0);

    // R2 source select
    trigSrcSw = 1;
    clearStats();
    pulseTrig(0);
    repeat (5) @(negedge clk);
    chk("R2 hw ignored when sw selected", trigCnt, 0);
    pulseTrig(1);
    repeat (5) @(negedge clk);
    chk("R2 sw selected", trigCnt, 1);
    trigSrcSw = 0;
    clearStats();
    pulseTrig(1);
    repeat (5) @(negedge clk);
    chk("R2 sw ignored when hw selected", trigCnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule